// File: doc/BRIEF.md
# Calendar Clock Core with Indexed Byte Access

This core keeps wall-clock time and a calendar in a small byte-addressed register space of 128 entries. Software reaches it through two write ports that share one data bus. A strobe on the index port selects a register, and a strobe on the data port then writes the selected register. The selected register is always visible on the read bus. The top bit of every index byte goes out on its own as an interrupt-mask output and takes no part in address decoding.

A one-cycle enable arrives from an external prescaler once per second. Each enable opens an update window. A read-only busy flag goes high at once, the time fields advance a fixed number of cycles later, and the flag drops at the end of the window. A control register picks packed-decimal or plain binary storage and 12-hour or 24-hour hours. A freeze bit in the same register holds the counters still while software loads a new time. A status register reports whether backup power has stayed good since reset. Every offset that holds no time or control field is ordinary byte storage.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset, seconds, minutes and hours read 0x00, weekday, day and month read 0x01, year reads 0x00, control A (offset 10) reads 0x26, control B (offset 11) reads 0x02, and status (offset 13) reads 0x80.
- R2: A strobe on idx_we loads wdata[6:0] as the register index and drives wdata[7] onto nmi_mask. A strobe on dat_we writes wdata to the indexed register. rdata shows the indexed register with no delay. Index bit 7 never changes which register is reached.
- R3: Offsets 1, 3, 5, 12 and 14 to 127 read back the last byte written to them.
- R4: When tick_1hz is sampled high, control A bit 7 reads 1 from the next cycle. The time fields change LEAD_CYC cycles after that sampling edge, and bit 7 returns to 0 TOTAL_CYC cycles after it. Software writes to A bit 7 have no effect. A tick that arrives while a window is open is ignored.
- R5: With control B bit 2 = 0 (packed decimal), each field counts in decimal. Seconds go 0x09 to 0x10, and 0x59 to 0x00 with a carry into minutes.
- R6: With control B bit 2 = 1 (binary), fields count in plain binary. Seconds go 59 (0x3B) to 0, and the carry takes minutes from 0x09 to 0x0A.
- R7: With control B bit 1 = 1 (24-hour), 23:59:59 rolls over to 00:00:00. The day of month advances, and the weekday (offset 6, 1 to 7) advances with 7 wrapping to 1.
- R8: With control B bit 1 = 0 (12-hour), the hour byte holds 1 to 12, with bit 7 = 1 for PM. The hour goes 11 AM (0x11) to 12 PM (0x92), 12 PM to 1 PM (0x81), and 11 PM (0x91) to 12 AM (0x12). Only the last of these steps carries into the day.
- R9: Day of month wraps after 28 or 29 days in month 2 (29 when the year is a multiple of 4), after 30 days in months 4, 6, 9 and 11, and after 31 days otherwise. Month 12 wraps to 1 and advances the year. Year 99 wraps to 0.
- R10: While control B bit 7 = 1, ticks start no update window, so A bit 7 stays 0 and no field changes. Clearing the bit lets the next tick count again.
- R11: Status bit 7 reads 1 from reset until a backup_lost pulse, and 0 after it. Status bits 6:0 read 0, and writes to the status register have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle enable from the prescaler, once per second |
| backup_lost | input | 1 | Pulse marking a loss of backup power |
| idx_we | input | 1 | Index port write strobe |
| dat_we | input | 1 | Data port write strobe |
| wdata | input | 8 | Shared write data for both ports |
| rdata | output | 8 | Contents of the indexed register |
| nmi_mask | output | 1 | Bit 7 of the last index byte written |

## Verification
The hardest case to reach from the ports is a carry that ripples through every field at once. One example is 23:59:59 on December 31 of year 99, which must land on day 1, month 1, year 0, with the weekday wrapping. A second example is the 11 PM to 12 AM step in 12-hour mode, which has to carry into the day while 11 AM does not. The bench loads such times directly through the data port. Random loads also favour 59, 23, 11 and end-of-month values in both encodings and both hour formats. A separate check follows a single window edge by edge, first with the index on the seconds register and then on the busy flag, so that the cycle in which the fields change and the cycle in which the flag drops are both observed at the ports.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   localparam int OFS_SEC  = 0;
   localparam int OFS_MIN  = 2;
   localparam int OFS_HR   = 4;
   localparam int OFS_WDAY = 6;
   localparam int OFS_MDAY = 7;
   localparam int OFS_MON  = 8;
   localparam int OFS_YR   = 9;
   localparam int OFS_CTLA = 10;
   localparam int OFS_CTLB = 11;
   localparam int OFS_STAT = 13;

   typedef struct packed {
      logic [7:0] sec;
      logic [7:0] min;
      logic [7:0] hr;
      logic [7:0] wday;
      logic [7:0] mday;
      logic [7:0] mon;
      logic [7:0] yr;
   } rtc_time_t;

   // stored byte -> binary value
   function automatic logic [6:0] fld_decode(logic [7:0] raw, logic bin_mode);
      if (bin_mode) return raw[6:0];
      return 7'(raw[7:4]) * 7'd10 + 7'(raw[3:0]);
   endfunction

   // binary value -> stored byte
   function automatic logic [7:0] fld_encode(logic [6:0] v, logic bin_mode);
      logic [6:0] tens;
      logic [6:0] ones;
      tens = v / 7'd10;
      ones = v - tens * 7'd10;
      if (bin_mode) return {1'b0, v};
      return {tens[3:0], ones[3:0]};
   endfunction

   function automatic logic [6:0] month_days(logic [6:0] mon, logic [6:0] yr);
      case (mon)
         7'd2:                     return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11:  return 7'd30;
         default:                  return 7'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_index_port.sv
module rtc_index_port #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idx_we,
   input  logic [7:0]        wdata,
   output logic [ADDR_W-1:0] idx_q,
   output logic              nmi_mask
);

   if (ADDR_W > 7) begin : g_bad_width
      $error("index width must leave bit 7 for the mask");
   end
   if (ADDR_W < 4) begin : g_small_width
      $error("index width too small for the control registers");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         nmi_mask <= 1'b0;
      end else if (idx_we) begin
         idx_q    <= wdata[ADDR_W-1:0];
         nmi_mask <= wdata[7];
      end
   end

endmodule

// File: rtl/rtc_update_timer.sv
module rtc_update_timer #(
   parameter int LEAD_CYC  = 4,
   parameter int TOTAL_CYC = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic freeze,
   output logic uip,
   output logic adv
);

   localparam int CNT_W = (TOTAL_CYC > 1) ? $clog2(TOTAL_CYC) : 1;
   localparam logic [CNT_W-1:0] ADV_AT  = CNT_W'(LEAD_CYC - 1);
   localparam logic [CNT_W-1:0] LAST_AT = CNT_W'(TOTAL_CYC - 1);

   if (LEAD_CYC < 1) begin : g_bad_lead
      $error("lead time must be at least one cycle");
   end
   if (TOTAL_CYC <= LEAD_CYC) begin : g_bad_window
      $error("window must outlast the lead time");
   end

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (freeze) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (tick) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end
      end else if (cnt_q == LAST_AT) begin
         busy_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign uip = busy_q;
   assign adv = busy_q && !freeze && (cnt_q == ADV_AT);

endmodule

// File: rtl/rtc_calendar_advance.sv
module rtc_calendar_advance
   import rtc_pkg::*;
(
   input  rtc_time_t cur,
   input  logic      bin_mode,
   input  logic      h24_mode,
   output rtc_time_t nxt
);

   logic [6:0] s, m, h12, h24, wd, d, mo, y, dim;
   logic [6:0] s_n, m_n, h_n, wd_n, d_n, mo_n, y_n, h12_n;
   logic       pm;
   logic       c_min, c_hr, c_day, c_mon, c_yr;

   always_comb begin
      s   = fld_decode(cur.sec, bin_mode);
      m   = fld_decode(cur.min, bin_mode);
      wd  = fld_decode(cur.wday, bin_mode);
      d   = fld_decode(cur.mday, bin_mode);
      mo  = fld_decode(cur.mon, bin_mode);
      y   = fld_decode(cur.yr, bin_mode);
      pm  = cur.hr[7];
      h12 = fld_decode({1'b0, cur.hr[6:0]}, bin_mode);
      if (h24_mode)          h24 = fld_decode(cur.hr, bin_mode);
      else if (h12 == 7'd12) h24 = pm ? 7'd12 : 7'd0;
      else                   h24 = pm ? h12 + 7'd12 : h12;
      dim = month_days(mo, y);

      c_min = (s >= 7'd59);
      c_hr  = c_min && (m >= 7'd59);
      c_day = c_hr  && (h24 >= 7'd23);
      c_mon = c_day && (d >= dim);
      c_yr  = c_mon && (mo >= 7'd12);

      s_n  = c_min ? 7'd0 : s + 7'd1;
      m_n  = !c_min ? m : (c_hr ? 7'd0 : m + 7'd1);
      h_n  = !c_hr  ? h24 : (c_day ? 7'd0 : h24 + 7'd1);
      wd_n = !c_day ? wd : ((wd >= 7'd7) ? 7'd1 : wd + 7'd1);
      d_n  = !c_day ? d : (c_mon ? 7'd1 : d + 7'd1);
      mo_n = !c_mon ? mo : (c_yr ? 7'd1 : mo + 7'd1);
      y_n  = !c_yr  ? y : ((y >= 7'd99) ? 7'd0 : y + 7'd1);

      if (h_n == 7'd0)       h12_n = 7'd12;
      else if (h_n > 7'd12)  h12_n = h_n - 7'd12;
      else                   h12_n = h_n;

      nxt.sec  = fld_encode(s_n, bin_mode);
      nxt.min  = fld_encode(m_n, bin_mode);
      nxt.hr   = h24_mode ? fld_encode(h_n, bin_mode)
                          : {(h_n >= 7'd12), fld_encode(h12_n, bin_mode)[6:0]};
      nxt.wday = fld_encode(wd_n, bin_mode);
      nxt.mday = fld_encode(d_n, bin_mode);
      nxt.mon  = fld_encode(mo_n, bin_mode);
      nxt.yr   = fld_encode(y_n, bin_mode);
   end

endmodule

// File: rtl/rtc_byte_ram.sv
module rtc_byte_ram #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= 8'h00;
         else if (we && (addr == ADDR_W'(i)))
            mem[i] <= wdata;
      end
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_pkg::*;
#(
   parameter int         ADDR_W     = 7,
   parameter int         LEAD_CYC   = 4,
   parameter int         TOTAL_CYC  = 12,
   parameter logic [7:0] CTLA_RESET = 8'h26,
   parameter logic [7:0] CTLB_RESET = 8'h02
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1hz,
   input  logic       backup_lost,
   input  logic       idx_we,
   input  logic       dat_we,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       nmi_mask
);

   localparam logic [ADDR_W-1:0] A_SEC  = ADDR_W'(OFS_SEC);
   localparam logic [ADDR_W-1:0] A_MIN  = ADDR_W'(OFS_MIN);
   localparam logic [ADDR_W-1:0] A_HR   = ADDR_W'(OFS_HR);
   localparam logic [ADDR_W-1:0] A_WDAY = ADDR_W'(OFS_WDAY);
   localparam logic [ADDR_W-1:0] A_MDAY = ADDR_W'(OFS_MDAY);
   localparam logic [ADDR_W-1:0] A_MON  = ADDR_W'(OFS_MON);
   localparam logic [ADDR_W-1:0] A_YR   = ADDR_W'(OFS_YR);
   localparam logic [ADDR_W-1:0] A_CTLA = ADDR_W'(OFS_CTLA);
   localparam logic [ADDR_W-1:0] A_CTLB = ADDR_W'(OFS_CTLB);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

   logic [ADDR_W-1:0] idx_q;
   logic              uip, adv, freeze;
   logic [6:0]        ctla_q;
   logic [7:0]        ctlb_q;
   logic              pwr_ok_q;
   rtc_time_t         t_q, t_nxt;
   logic              special, ram_we;
   logic [7:0]        ram_rdata;

   assign freeze = ctlb_q[7];

   rtc_index_port #(.ADDR_W(ADDR_W)) u_port (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .wdata(wdata),
      .idx_q(idx_q), .nmi_mask(nmi_mask)
   );

   rtc_update_timer #(.LEAD_CYC(LEAD_CYC), .TOTAL_CYC(TOTAL_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .freeze(freeze),
      .uip(uip), .adv(adv)
   );

   rtc_calendar_advance u_adv (
      .cur(t_q), .bin_mode(ctlb_q[2]), .h24_mode(ctlb_q[1]), .nxt(t_nxt)
   );

   always_comb begin
      case (idx_q)
         A_SEC, A_MIN, A_HR, A_WDAY, A_MDAY, A_MON, A_YR,
         A_CTLA, A_CTLB, A_STAT: special = 1'b1;
         default:                special = 1'b0;
      endcase
   end

   assign ram_we = dat_we && !special;

   rtc_byte_ram #(.ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .addr(idx_q),
      .wdata(wdata), .rdata(ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         t_q      <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, wday: 8'h01,
                       mday: 8'h01, mon: 8'h01, yr: 8'h00};
         ctla_q   <= CTLA_RESET[6:0];
         ctlb_q   <= CTLB_RESET;
         pwr_ok_q <= 1'b1;
      end else begin
         if (adv) t_q <= t_nxt;
         if (dat_we) begin
            case (idx_q)
               A_SEC:   t_q.sec  <= wdata;
               A_MIN:   t_q.min  <= wdata;
               A_HR:    t_q.hr   <= wdata;
               A_WDAY:  t_q.wday <= wdata;
               A_MDAY:  t_q.mday <= wdata;
               A_MON:   t_q.mon  <= wdata;
               A_YR:    t_q.yr   <= wdata;
               A_CTLA:  ctla_q   <= wdata[6:0];
               A_CTLB:  ctlb_q   <= wdata;
               default: ;
            endcase
         end
         if (backup_lost) pwr_ok_q <= 1'b0;
      end
   end

   always_comb begin
      case (idx_q)
         A_SEC:   rdata = t_q.sec;
         A_MIN:   rdata = t_q.min;
         A_HR:    rdata = t_q.hr;
         A_WDAY:  rdata = t_q.wday;
         A_MDAY:  rdata = t_q.mday;
         A_MON:   rdata = t_q.mon;
         A_YR:    rdata = t_q.yr;
         A_CTLA:  rdata = {uip, ctla_q};
         A_CTLB:  rdata = ctlb_q;
         A_STAT:  rdata = {pwr_ok_q, 7'd0};
         default: rdata = ram_rdata;
      endcase
   end

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk #(
   parameter int ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_1hz,
   input logic              idx_we,
   input logic              dat_we,
   input logic [7:0]        wdata,
   input logic              nmi_mask,
   input logic              uip,
   input logic              adv,
   input logic              freeze,
   input logic [7:0]        sec_q,
   input logic              pwr_ok_q,
   input logic [ADDR_W-1:0] idx_q
);

   assert_nmi_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idx_we |=> (nmi_mask == $past(wdata[7])));

   assert_uip_from_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uip) |-> $past(tick_1hz));

   assert_single_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> !adv);

   assert_sec_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !(dat_we && idx_q == '0)) |=> $stable(sec_q));

   assert_freeze_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> !uip);

   assert_valid_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok_q |=> !pwr_ok_q);

endmodule

bind rtc_calendar_core rtc_calendar_core_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .idx_we(idx_we),
   .dat_we(dat_we), .wdata(wdata), .nmi_mask(nmi_mask), .uip(uip),
   .adv(adv), .freeze(freeze), .sec_q(t_q.sec), .pwr_ok_q(pwr_ok_q),
   .idx_q(idx_q)
);

// File: tb/rtc_calendar_core_bench.sv
module rtc_calendar_core_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LEAD      = 4;
   localparam int TOTAL     = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic       backup_lost = 1'b0;
   logic       idx_we = 1'b0;
   logic       dat_we = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       nmi_mask;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   rtc_calendar_core #(.LEAD_CYC(LEAD), .TOTAL_CYC(TOTAL)) u_rtc_calendar_core (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .backup_lost(backup_lost),
      .idx_we(idx_we), .dat_we(dat_we), .wdata(wdata), .rdata(rdata),
      .nmi_mask(nmi_mask)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check8(string tag, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] addr, logic [7:0] val);
      @(negedge clk); idx_we = 1'b1; wdata = addr;
      @(negedge clk); idx_we = 1'b0; dat_we = 1'b1; wdata = val;
      @(negedge clk); dat_we = 1'b0;
   endtask

   task automatic rd(logic [7:0] addr, output logic [7:0] val);
      @(negedge clk); idx_we = 1'b1; wdata = addr;
      @(negedge clk); idx_we = 1'b0; val = rdata;
   endtask

   // leaves the bench at the first negedge after the sampling edge
   task automatic pulse_tick();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   task automatic tick_full();
      pulse_tick();
      repeat (TOTAL + 2) @(negedge clk);
   endtask

   task automatic load(logic [7:0] s, logic [7:0] m, logic [7:0] h, logic [7:0] wd,
                       logic [7:0] d, logic [7:0] mo, logic [7:0] y);
      wr(0, s); wr(2, m); wr(4, h); wr(6, wd); wr(7, d); wr(8, mo); wr(9, y);
   endtask

   task automatic read_all(output logic [55:0] v);
      logic [7:0] b0, b2, b4, b6, b7, b8, b9;
      rd(0, b0); rd(2, b2); rd(4, b4); rd(6, b6); rd(7, b7); rd(8, b8); rd(9, b9);
      v = {b0, b2, b4, b6, b7, b8, b9};
   endtask

   function automatic logic [7:0] benc(int v, bit bin);
      return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] benc_hr(int h, bit bin, bit h24);
      int hh;
      if (h24) return benc(h, bin);
      hh = h % 12;
      if (hh == 0) hh = 12;
      return (h >= 12 ? 8'h80 : 8'h00) | benc(hh, bin);
   endfunction

   function automatic int bdim(int mo, int y);
      if (mo == 2) return (y % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   task automatic model_next(inout int s, inout int m, inout int h, inout int wd,
                             inout int d, inout int mo, inout int y);
      s++;
      if (s > 59) begin
         s = 0; m++;
         if (m > 59) begin
            m = 0; h++;
            if (h > 23) begin
               h = 0;
               wd = (wd == 7) ? 1 : wd + 1;
               d++;
               if (d > bdim(mo, y)) begin
                  d = 1; mo++;
                  if (mo > 12) begin
                     mo = 1; y = (y + 1) % 100;
                  end
               end
            end
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0]  v;
      logic [55:0] all;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      read_all(all);
      check8("R1 seconds..minutes..hours", all[55:48] | all[47:40] | all[39:32], 8'h00);
      check8("R1 weekday", all[31:24], 8'h01);
      check8("R1 day", all[23:16], 8'h01);
      check8("R1 month", all[15:8], 8'h01);
      check8("R1 year", all[7:0], 8'h00);
      rd(10, v); check8("R1 control A", v, 8'h26);
      rd(11, v); check8("R1 control B", v, 8'h02);
      rd(13, v); check8("R1 status", v, 8'h80);

      // R2 index/data ports and mask bit
      wr(8'h85, 8'h5A);
      check8("R2 nmi_mask set", {7'd0, nmi_mask}, 8'h01);
      rd(8'h05, v);
      check8("R2 masked index reaches offset 5", v, 8'h5A);
      check8("R2 nmi_mask clear", {7'd0, nmi_mask}, 8'h00);

      // R3 byte storage
      wr(8'h20, 8'hC3); wr(8'h7F, 8'h3C); wr(8'h0C, 8'h11); wr(8'h01, 8'h99);
      rd(8'h20, v); check8("R3 offset 0x20", v, 8'hC3);
      rd(8'h7F, v); check8("R3 offset 0x7F", v, 8'h3C);
      rd(8'h0C, v); check8("R3 offset 0x0C", v, 8'h11);
      rd(8'h01, v); check8("R3 offset 0x01", v, 8'h99);

      // R4 window timing, seconds view
      wr(0, 8'h05);
      rd(0, v);
      pulse_tick();
      repeat (LEAD - 1) @(negedge clk);
      check8("R4 seconds before advance", rdata, 8'h05);
      @(negedge clk);
      check8("R4 seconds after advance", rdata, 8'h06);
      repeat (TOTAL) @(negedge clk);
      // R4 window timing, flag view
      rd(10, v);
      pulse_tick();
      check8("R4 flag high after tick", {7'd0, rdata[7]}, 8'h01);
      tick_1hz = 1'b1;  // extra tick inside window must be ignored
      @(negedge clk); tick_1hz = 1'b0;
      repeat (TOTAL - 2) @(negedge clk);
      check8("R4 flag high at window end", {7'd0, rdata[7]}, 8'h01);
      @(negedge clk);
      check8("R4 flag low after window", {7'd0, rdata[7]}, 8'h00);
      repeat (4) @(negedge clk);
      check8("R4 no second window", {7'd0, rdata[7]}, 8'h00);
      rd(0, v); check8("R4 one advance per window", v, 8'h07);
      wr(10, 8'hFF); rd(10, v); check8("R4 flag not writable", v, 8'h7F);
      wr(10, 8'h26);

      // R5 packed decimal
      wr(11, 8'h02);
      wr(0, 8'h09); tick_full(); rd(0, v); check8("R5 0x09 to 0x10", v, 8'h10);
      wr(0, 8'h59); wr(2, 8'h07); tick_full();
      rd(0, v); check8("R5 seconds wrap", v, 8'h00);
      rd(2, v); check8("R5 minute carry", v, 8'h08);

      // R6 binary
      wr(11, 8'h06);
      wr(0, 8'h3B); wr(2, 8'h09); tick_full();
      rd(0, v); check8("R6 seconds wrap", v, 8'h00);
      rd(2, v); check8("R6 minute binary", v, 8'h0A);

      // R7 24-hour day rollover
      wr(11, 8'h02);
      load(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h06, 8'h10); tick_full();
      read_all(all);
      check8("R7 hour", all[39:32], 8'h00);
      check8("R7 minutes", all[47:40], 8'h00);
      check8("R7 weekday wrap", all[31:24], 8'h01);
      check8("R7 day", all[23:16], 8'h16);

      // R8 12-hour
      wr(11, 8'h00);
      load(8'h59, 8'h59, 8'h11, 8'h03, 8'h10, 8'h06, 8'h10); tick_full();
      rd(4, v); check8("R8 11AM to 12PM", v, 8'h92);
      rd(7, v); check8("R8 no day carry at noon", v, 8'h10);
      wr(0, 8'h59); wr(2, 8'h59); tick_full();
      rd(4, v); check8("R8 12PM to 1PM", v, 8'h81);
      load(8'h59, 8'h59, 8'h91, 8'h03, 8'h10, 8'h06, 8'h10); tick_full();
      rd(4, v); check8("R8 11PM to 12AM", v, 8'h12);
      rd(7, v); check8("R8 day carry at midnight", v, 8'h11);
      rd(6, v); check8("R8 weekday at midnight", v, 8'h04);

      // R9 month lengths
      wr(11, 8'h02);
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h21); tick_full();
      read_all(all);
      check8("R9 30-day month day", all[23:16], 8'h01);
      check8("R9 30-day month month", all[15:8], 8'h05);
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23); tick_full();
      read_all(all);
      check8("R9 Feb non-leap", {all[23:16]}, 8'h01);
      check8("R9 Feb non-leap month", all[15:8], 8'h03);
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24); tick_full();
      rd(7, v); check8("R9 Feb leap day 29", v, 8'h29);
      load(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24); tick_full();
      rd(8, v); check8("R9 Feb 29 to March", v, 8'h03);
      load(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99); tick_full();
      read_all(all);
      check8("R9 year wrap", all[7:0], 8'h00);
      check8("R9 month wrap", all[15:8], 8'h01);
      check8("R9 day wrap", all[23:16], 8'h01);

      // R10 freeze
      wr(11, 8'h82); wr(0, 8'h05);
      rd(10, v);
      pulse_tick();
      check8("R10 no flag while frozen", {7'd0, rdata[7]}, 8'h00);
      repeat (TOTAL + 2) @(negedge clk);
      rd(0, v); check8("R10 seconds held", v, 8'h05);
      wr(11, 8'h02); tick_full();
      rd(0, v); check8("R10 counting resumes", v, 8'h06);

      // R11 power valid
      wr(13, 8'h00); rd(13, v); check8("R11 status write ignored", v, 8'h80);
      @(negedge clk); backup_lost = 1'b1;
      @(negedge clk); backup_lost = 1'b0;
      rd(13, v); check8("R11 status after loss", v, 8'h00);
      wr(13, 8'hFF); rd(13, v); check8("R11 status stays low", v, 8'h00);

      // random loads in all modes (R5..R9)
      for (int it = 0; it < 40; it++) begin
         bit bin, h24;
         int s, m, h, wd, d, mo, y;
         logic [55:0] exp;
         bin = 1'($urandom % 2);
         h24 = 1'($urandom % 2);
         s  = ($urandom % 3 == 0) ? int'($urandom % 60) : 59;
         m  = ($urandom % 3 == 0) ? int'($urandom % 60) : 59;
         case ($urandom % 4)
            0: h = 23;
            1: h = 11;
            2: h = 12;
            default: h = int'($urandom % 24);
         endcase
         wd = 1 + int'($urandom % 7);
         mo = 1 + int'($urandom % 12);
         y  = int'($urandom % 100);
         d  = ($urandom % 2 == 0) ? bdim(mo, y) : 1 + int'($urandom % bdim(mo, y));
         wr(11, {5'd0, bin, h24, 1'b0});
         load(benc(s, bin), benc(m, bin), benc_hr(h, bin, h24), benc(wd, bin),
              benc(d, bin), benc(mo, bin), benc(y, bin));
         tick_full();
         model_next(s, m, h, wd, d, mo, y);
         exp = {benc(s, bin), benc(m, bin), benc_hr(h, bin, h24), benc(wd, bin),
                benc(d, bin), benc(mo, bin), benc(y, bin)};
         read_all(all);
         checks++;
         if (all !== exp) begin
            errors++;
            $display("FAIL R9 random rollover (R5 R6 R7 R8) iter %0d: got 0x%014h expected 0x%014h",
                     it, all, exp);
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule